// File: doc/BRIEF.md
# Hybrid Last-Level Cache Lookup and Fill Sequencer

This block is the per-node request controller for one slice of a distributed last-level cache. Each slice is split by ways into a private partition used only by the local core, a shared partition open to every core, and a directory that records which node's private partition holds a given line. The sequencer takes one miss at a time from the local L1. It looks the line up in a fixed order: first the local slice (private and shared tags together), then the shared partition of the line's home node, then the home node's directory. If the directory names an owner, that node's private partition is probed. When every lookup misses, the sequencer goes to off-chip memory.

Wherever the line is found, the sequencer emits one line-movement command that keeps the aggregate cache free of duplicates:
- A shared-partition hit pulls the line into the local private partition.
- A hit in a remote private partition pushes the line out to the home shared partition.
- A memory fill lands in the local private partition.
- Any line displaced from the local private partition moves to its own home shared partition, and its directory entry is cleared in the same command.

Remote nodes and memory are reached through simple valid/response handshakes. The data arrays and the on-chip network lie outside the block.

Top module: `hllc_fill_seq`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, lk_valid, msg_valid, mem_req_valid and mv_valid are all 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. In the next cycle lk_valid is 1 and line_addr equals the request line. req_ready stays 0 until the response has been given.
- R3: If lk_priv_hit is 1 during the local lookup, the response carries rsp_src 0 (local private). No move command and no message are issued.
- R4: If the local lookup hits only in the shared partition, the response carries rsp_src 1. One move command is issued with mv_op 1 (shared to private), source and destination both equal to node_id, mv_dir 1 (add entry) and mv_dir_node equal to the home of the line.
- R5: The home shared lookup is a message with msg_kind 0 sent to the home node. It is skipped when the home equals node_id. On a hit, the response carries rsp_src 2 and the move is mv_op 1 from the home node to node_id, with mv_dir 1 at the home.
- R6: The directory lookup is msg_kind 1 sent to the home node. A directory hit is followed by msg_kind 2 sent to the reported owner. A probe hit gives rsp_src 3 and the move mv_op 2 (private to shared) from the owner to the home, with mv_dir 2 (clear) at the home.
- R7: A directory miss or a probe miss raises mem_req_valid and holds it until mem_rsp_valid. The move is then mv_op 3 (memory to private) into node_id, with mv_dir 1 at the home, and the response carries rsp_src 4.
- R8: After any fill into the local private partition, if vic_valid is 1 the sequencer issues mv_op 2 for vic_line from node_id to the home of vic_line. That command has mv_dir 2 and mv_dir_node equal to that same home.
- R9: The home node of a line is the line address modulo NODES.
- R10: While msg_valid is 1 and no msg_rsp_valid has arrived, msg_kind and msg_node hold their values. At most one of lk_valid, msg_valid and mem_req_valid is 1 in any cycle.
- R11: rsp_valid is a single-cycle pulse, and exactly one pulse is given per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | Identity of this node |
| req_valid | input | 1 | L1 request valid |
| req_line | input | LINE_W | Requested line address |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_src | output | 3 | Where the line was found (0..4) |
| line_addr | output | LINE_W | Line under service, used by every lookup |
| lk_valid | output | 1 | Local slice lookup strobe |
| lk_priv_hit | input | 1 | Local private partition hit |
| lk_shr_hit | input | 1 | Local shared partition hit |
| msg_valid | output | 1 | Message toward a node |
| msg_kind | output | 2 | 0 shared lookup, 1 directory lookup, 2 private probe |
| msg_node | output | NODE_W | Target node of the message |
| msg_rsp_valid | input | 1 | Message response valid |
| msg_rsp_hit | input | 1 | Message response hit |
| msg_rsp_owner | input | NODE_W | Owner node reported by a directory hit |
| mem_req_valid | output | 1 | Off-chip read request |
| mem_rsp_valid | input | 1 | Off-chip data returned |
| vic_valid | input | 1 | Local private fill displaced a line |
| vic_line | input | LINE_W | Displaced line address |
| mv_valid | output | 1 | Move command strobe |
| mv_op | output | 2 | 1 shared to private, 2 private to shared, 3 memory to private |
| mv_line | output | LINE_W | Line moved |
| mv_src_node | output | NODE_W | Node the line leaves |
| mv_dst_node | output | NODE_W | Node the line enters |
| mv_dir | output | 2 | 0 no change, 1 add entry, 2 clear entry |
| mv_dir_node | output | NODE_W | Node whose directory is updated |

## Verification
The corner cases in the bench are these:
- A line whose home is the requesting node. A sequencer that still sent the home shared lookup would show a msg_kind 0 message addressed to itself.
- A directory hit whose probe then misses. It must fall through to memory; a design that stalled or answered "remote" would give the wrong rsp_src, or none at all.
- A memory fill that displaces a victim. This checks that the eviction move targets the victim's home, not the requested line's home, and clears that directory entry; a design that dropped the victim would leave a stale owner in the directory.
- Memory latency longer than one cycle. This checks that the off-chip request is held until data returns.

// File: rtl/hllc_pkg.sv
package hllc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOCAL, ST_HOME_SHR, ST_DIR, ST_REMOTE, ST_OFFCHIP, ST_FILL, ST_DONE
   } seq_st_e;

   typedef enum logic [1:0] {
      OP_NONE     = 2'd0,
      OP_SHR2PRIV = 2'd1,
      OP_PRIV2SHR = 2'd2,
      OP_MEM2PRIV = 2'd3
   } move_op_e;

   typedef enum logic [1:0] {
      DIR_KEEP = 2'd0,
      DIR_ADD  = 2'd1,
      DIR_CLR  = 2'd2
   } dir_upd_e;

   typedef enum logic [1:0] {
      K_SHR_LOOKUP = 2'd0,
      K_DIR_LOOKUP = 2'd1,
      K_PRIV_PROBE = 2'd2
   } msg_kind_e;

   typedef enum logic [2:0] {
      SRC_LPRIV  = 3'd0,
      SRC_LSHR   = 3'd1,
      SRC_HSHR   = 3'd2,
      SRC_REMOTE = 3'd3,
      SRC_MEM    = 3'd4
   } hit_src_e;

endpackage

// File: rtl/hllc_home_map.sv
module hllc_home_map #(
   parameter int LINE_W = 26,
   parameter int NODES  = 4,
   localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
   input  logic [LINE_W-1:0] line,
   output logic [NODE_W-1:0] home
);
   localparam logic [LINE_W-1:0] NODES_L = LINE_W'(NODES);
   logic [LINE_W-1:0] rem;

   // R9: interleave lines across nodes by the line address modulo NODES
   always_comb rem = line % NODES_L;
   assign home = rem[NODE_W-1:0];

   logic unused_hi;
   generate
      if (LINE_W > NODE_W) begin : g_hi
         assign unused_hi = ^rem[LINE_W-1:NODE_W];
      end else begin : g_nohi
         assign unused_hi = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hllc_seq_fsm.sv
module hllc_seq_fsm
   import hllc_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int NODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] node_id,
   input  logic              req_valid,
   input  logic [LINE_W-1:0] req_line,
   input  logic [NODE_W-1:0] home_node,
   input  logic              lk_priv_hit,
   input  logic              lk_shr_hit,
   input  logic              msg_rsp_valid,
   input  logic              msg_rsp_hit,
   input  logic [NODE_W-1:0] msg_rsp_owner,
   input  logic              mem_rsp_valid,
   input  logic              vic_valid,
   input  logic [LINE_W-1:0] vic_line,
   input  logic [NODE_W-1:0] vic_home,
   output seq_st_e           state,
   output logic [LINE_W-1:0] cur_line,
   output logic [NODE_W-1:0] owner,
   output hit_src_e          src_q,
   output logic              mvq_valid,
   output move_op_e          mvq_op,
   output logic [LINE_W-1:0] mvq_line,
   output logic [NODE_W-1:0] mvq_src,
   output logic [NODE_W-1:0] mvq_dst,
   output dir_upd_e          mvq_dir,
   output logic [NODE_W-1:0] mvq_dir_node
);
   seq_st_e  nxt;
   hit_src_e src_n;
   logic [NODE_W-1:0] owner_n;

   always_comb begin
      nxt          = state;
      src_n        = src_q;
      owner_n      = owner;
      mvq_valid    = 1'b0;
      mvq_op       = OP_NONE;
      mvq_line     = cur_line;
      mvq_src      = node_id;
      mvq_dst      = node_id;
      mvq_dir      = DIR_KEEP;
      mvq_dir_node = home_node;
      unique case (state)
         ST_IDLE: if (req_valid) nxt = ST_LOCAL;
         ST_LOCAL: begin
            if (lk_priv_hit) begin
               src_n = SRC_LPRIV;
               nxt   = ST_DONE;
            end else if (lk_shr_hit) begin
               src_n     = SRC_LSHR;
               mvq_valid = 1'b1;
               mvq_op    = OP_SHR2PRIV;
               mvq_dir   = DIR_ADD;
               nxt       = ST_FILL;
            end else if (home_node == node_id) begin
               nxt = ST_DIR;          // own shared slice already searched
            end else begin
               nxt = ST_HOME_SHR;
            end
         end
         ST_HOME_SHR: if (msg_rsp_valid) begin
            if (msg_rsp_hit) begin
               src_n     = SRC_HSHR;
               mvq_valid = 1'b1;
               mvq_op    = OP_SHR2PRIV;
               mvq_src   = home_node;
               mvq_dir   = DIR_ADD;
               nxt       = ST_FILL;
            end else begin
               nxt = ST_DIR;
            end
         end
         ST_DIR: if (msg_rsp_valid) begin
            if (msg_rsp_hit) begin
               owner_n = msg_rsp_owner;
               nxt     = ST_REMOTE;
            end else begin
               nxt = ST_OFFCHIP;
            end
         end
         ST_REMOTE: if (msg_rsp_valid) begin
            if (msg_rsp_hit) begin
               src_n     = SRC_REMOTE;
               mvq_valid = 1'b1;
               mvq_op    = OP_PRIV2SHR;
               mvq_src   = owner;
               mvq_dst   = home_node;
               mvq_dir   = DIR_CLR;
               nxt       = ST_DONE;
            end else begin
               nxt = ST_OFFCHIP;
            end
         end
         ST_OFFCHIP: if (mem_rsp_valid) begin
            src_n     = SRC_MEM;
            mvq_valid = 1'b1;
            mvq_op    = OP_MEM2PRIV;
            mvq_dir   = DIR_ADD;
            nxt       = ST_FILL;
         end
         ST_FILL: begin
            if (vic_valid) begin
               mvq_valid    = 1'b1;
               mvq_op       = OP_PRIV2SHR;
               mvq_line     = vic_line;
               mvq_dst      = vic_home;
               mvq_dir      = DIR_CLR;
               mvq_dir_node = vic_home;
            end
            nxt = ST_DONE;
         end
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_line <= '0;
         owner    <= '0;
         src_q    <= SRC_LPRIV;
      end else begin
         state <= nxt;
         src_q <= src_n;
         owner <= owner_n;
         if (state == ST_IDLE && req_valid) cur_line <= req_line;
      end
   end
endmodule

// File: rtl/hllc_move_port.sv
module hllc_move_port
   import hllc_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int NODE_W = 2,
   parameter bit MV_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  move_op_e          in_op,
   input  logic [LINE_W-1:0] in_line,
   input  logic [NODE_W-1:0] in_src,
   input  logic [NODE_W-1:0] in_dst,
   input  dir_upd_e          in_dir,
   input  logic [NODE_W-1:0] in_dir_node,
   output logic              mv_valid,
   output logic [1:0]        mv_op,
   output logic [LINE_W-1:0] mv_line,
   output logic [NODE_W-1:0] mv_src_node,
   output logic [NODE_W-1:0] mv_dst_node,
   output logic [1:0]        mv_dir,
   output logic [NODE_W-1:0] mv_dir_node
);
   generate
      if (MV_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mv_valid    <= 1'b0;
               mv_op       <= OP_NONE;
               mv_line     <= '0;
               mv_src_node <= '0;
               mv_dst_node <= '0;
               mv_dir      <= DIR_KEEP;
               mv_dir_node <= '0;
            end else begin
               mv_valid <= in_valid;
               if (in_valid) begin
                  mv_op       <= in_op;
                  mv_line     <= in_line;
                  mv_src_node <= in_src;
                  mv_dst_node <= in_dst;
                  mv_dir      <= in_dir;
                  mv_dir_node <= in_dir_node;
               end
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk  = clk ^ rst_n;
         assign mv_valid    = in_valid;
         assign mv_op       = in_op;
         assign mv_line     = in_line;
         assign mv_src_node = in_src;
         assign mv_dst_node = in_dst;
         assign mv_dir      = in_dir;
         assign mv_dir_node = in_dir_node;
      end
   endgenerate
endmodule

// File: rtl/hllc_fill_seq.sv
module hllc_fill_seq
   import hllc_pkg::*;
#(
   parameter int LINE_W = 26,
   parameter int NODES  = 4,
   parameter bit MV_REG = 1'b1,
   localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] node_id,
   input  logic              req_valid,
   input  logic [LINE_W-1:0] req_line,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [2:0]        rsp_src,
   output logic [LINE_W-1:0] line_addr,
   output logic              lk_valid,
   input  logic              lk_priv_hit,
   input  logic              lk_shr_hit,
   output logic              msg_valid,
   output logic [1:0]        msg_kind,
   output logic [NODE_W-1:0] msg_node,
   input  logic              msg_rsp_valid,
   input  logic              msg_rsp_hit,
   input  logic [NODE_W-1:0] msg_rsp_owner,
   output logic              mem_req_valid,
   input  logic              mem_rsp_valid,
   input  logic              vic_valid,
   input  logic [LINE_W-1:0] vic_line,
   output logic              mv_valid,
   output logic [1:0]        mv_op,
   output logic [LINE_W-1:0] mv_line,
   output logic [NODE_W-1:0] mv_src_node,
   output logic [NODE_W-1:0] mv_dst_node,
   output logic [1:0]        mv_dir,
   output logic [NODE_W-1:0] mv_dir_node
);
   if (NODES < 2) begin : g_chk_nodes
      $error("hllc_fill_seq: NODES must be at least 2");
   end
   if (LINE_W <= NODE_W) begin : g_chk_line
      $error("hllc_fill_seq: LINE_W must exceed the node id width");
   end

   seq_st_e           state;
   logic [LINE_W-1:0] cur_line;
   logic [NODE_W-1:0] owner, home_node, vic_home;
   hit_src_e          src_q;
   logic              mvq_valid;
   move_op_e          mvq_op;
   logic [LINE_W-1:0] mvq_line;
   logic [NODE_W-1:0] mvq_src, mvq_dst, mvq_dir_node;
   dir_upd_e          mvq_dir;

   hllc_home_map #(.LINE_W(LINE_W), .NODES(NODES)) u_home_cur (
      .line(cur_line), .home(home_node));
   hllc_home_map #(.LINE_W(LINE_W), .NODES(NODES)) u_home_vic (
      .line(vic_line), .home(vic_home));

   hllc_seq_fsm #(.LINE_W(LINE_W), .NODE_W(NODE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .node_id(node_id),
      .req_valid(req_valid), .req_line(req_line), .home_node(home_node),
      .lk_priv_hit(lk_priv_hit), .lk_shr_hit(lk_shr_hit),
      .msg_rsp_valid(msg_rsp_valid), .msg_rsp_hit(msg_rsp_hit),
      .msg_rsp_owner(msg_rsp_owner), .mem_rsp_valid(mem_rsp_valid),
      .vic_valid(vic_valid), .vic_line(vic_line), .vic_home(vic_home),
      .state(state), .cur_line(cur_line), .owner(owner), .src_q(src_q),
      .mvq_valid(mvq_valid), .mvq_op(mvq_op), .mvq_line(mvq_line),
      .mvq_src(mvq_src), .mvq_dst(mvq_dst), .mvq_dir(mvq_dir),
      .mvq_dir_node(mvq_dir_node));

   hllc_move_port #(.LINE_W(LINE_W), .NODE_W(NODE_W), .MV_REG(MV_REG)) u_move (
      .clk(clk), .rst_n(rst_n),
      .in_valid(mvq_valid), .in_op(mvq_op), .in_line(mvq_line),
      .in_src(mvq_src), .in_dst(mvq_dst), .in_dir(mvq_dir),
      .in_dir_node(mvq_dir_node),
      .mv_valid(mv_valid), .mv_op(mv_op), .mv_line(mv_line),
      .mv_src_node(mv_src_node), .mv_dst_node(mv_dst_node),
      .mv_dir(mv_dir), .mv_dir_node(mv_dir_node));

   // port-side decode of the sequencer state
   always_comb begin
      req_ready     = (state == ST_IDLE);
      rsp_valid     = (state == ST_DONE);
      rsp_src       = src_q;
      line_addr     = cur_line;
      lk_valid      = (state == ST_LOCAL);
      mem_req_valid = (state == ST_OFFCHIP);
      msg_valid     = 1'b0;
      msg_kind      = K_SHR_LOOKUP;
      msg_node      = home_node;
      unique case (state)
         ST_HOME_SHR: msg_valid = 1'b1;
         ST_DIR: begin
            msg_valid = 1'b1;
            msg_kind  = K_DIR_LOOKUP;
         end
         ST_REMOTE: begin
            msg_valid = 1'b1;
            msg_kind  = K_PRIV_PROBE;
            msg_node  = owner;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/hllc_fill_seq_chk.sv
module hllc_fill_seq_chk #(
   parameter int NODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NODE_W-1:0] node_id,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              lk_valid,
   input logic              msg_valid,
   input logic [1:0]        msg_kind,
   input logic [NODE_W-1:0] msg_node,
   input logic              msg_rsp_valid,
   input logic              mem_req_valid,
   input logic              mem_rsp_valid,
   input logic              mv_valid,
   input logic [1:0]        mv_op,
   input logic [NODE_W-1:0] mv_dst_node,
   input logic [1:0]        mv_dir,
   input logic [NODE_W-1:0] mv_dir_node
);
   p_accept_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (lk_valid && !req_ready));

   p_busy_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_valid, msg_valid, mem_req_valid}));

   p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_rsp_valid) |=>
         (msg_valid && $stable(msg_kind) && $stable(msg_node)));

   p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_rsp_valid) |=> mem_req_valid);

   p_fill_adds_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && (mv_op == 2'd1 || mv_op == 2'd3)) |->
         (mv_dir == 2'd1 && mv_dst_node == node_id));

   p_evict_clears_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && mv_op == 2'd2) |-> (mv_dir == 2'd2 && mv_dst_node == mv_dir_node));

   p_skip_own_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 2'd0) |-> (msg_node != node_id));
endmodule

bind hllc_fill_seq hllc_fill_seq_chk #(.NODE_W(NODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .node_id(node_id), .req_valid(req_valid),
   .req_ready(req_ready), .rsp_valid(rsp_valid), .lk_valid(lk_valid),
   .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
   .msg_rsp_valid(msg_rsp_valid), .mem_req_valid(mem_req_valid),
   .mem_rsp_valid(mem_rsp_valid), .mv_valid(mv_valid), .mv_op(mv_op),
   .mv_dst_node(mv_dst_node), .mv_dir(mv_dir), .mv_dir_node(mv_dir_node));

// File: tb/hllc_fill_seq_bench.sv
module hllc_fill_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LINE_W  = 26;
   localparam int NODES   = 4;
   localparam int NODE_W  = 2;
   localparam int MEM_LAT = 3;
   localparam int WD_CYC  = 20000;
   localparam logic [NODE_W-1:0] ME = 2'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              req_valid = 1'b0;
   logic [LINE_W-1:0] req_line = '0;
   logic              req_ready, rsp_valid, lk_valid, msg_valid, mem_req_valid, mv_valid;
   logic [2:0]        rsp_src;
   logic [LINE_W-1:0] line_addr, mv_line;
   logic [1:0]        msg_kind, mv_op, mv_dir;
   logic [NODE_W-1:0] msg_node, mv_src_node, mv_dst_node, mv_dir_node;
   logic              lk_priv_hit = 1'b0, lk_shr_hit = 1'b0;
   logic              msg_rsp_valid = 1'b0, msg_rsp_hit = 1'b0;
   logic [NODE_W-1:0] msg_rsp_owner = '0;
   logic              mem_rsp_valid = 1'b0;
   logic              vic_valid = 1'b0;
   logic [LINE_W-1:0] vic_line = '0;

   // responder configuration, written by the scenario tasks only
   logic              cfg_shr_hit = 1'b0, cfg_dir_hit = 1'b0, cfg_probe_hit = 1'b0;
   logic [NODE_W-1:0] cfg_owner = '0;

   hllc_fill_seq #(.LINE_W(LINE_W), .NODES(NODES)) u_hllc_fill_seq (
      .clk(clk), .rst_n(rst_n), .node_id(ME),
      .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_src(rsp_src), .line_addr(line_addr),
      .lk_valid(lk_valid), .lk_priv_hit(lk_priv_hit), .lk_shr_hit(lk_shr_hit),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
      .msg_rsp_valid(msg_rsp_valid), .msg_rsp_hit(msg_rsp_hit),
      .msg_rsp_owner(msg_rsp_owner), .mem_req_valid(mem_req_valid),
      .mem_rsp_valid(mem_rsp_valid), .vic_valid(vic_valid), .vic_line(vic_line),
      .mv_valid(mv_valid), .mv_op(mv_op), .mv_line(mv_line),
      .mv_src_node(mv_src_node), .mv_dst_node(mv_dst_node),
      .mv_dir(mv_dir), .mv_dir_node(mv_dir_node));

   // logs, written only by the monitor below
   int mv_n = 0, msg_n = 0, rsp_n = 0, busy_ready = 0, mem_run = 0, mem_last = 0;
   logic [1:0]        lg_op [64];
   logic [LINE_W-1:0] lg_line [64];
   logic [NODE_W-1:0] lg_src [64], lg_dst [64], lg_dnode [64], lg_mnode [64];
   logic [1:0]        lg_dir [64], lg_kind [64];
   logic [2:0]        lg_rsp [64];
   logic [LINE_W-1:0] lk_seen;

   always @(negedge clk) begin
      msg_rsp_valid <= 1'b0;
      msg_rsp_hit   <= 1'b0;
      mem_rsp_valid <= 1'b0;
      if (rst_n) begin
         if (mv_valid) begin
            lg_op[mv_n % 64]    <= mv_op;
            lg_line[mv_n % 64]  <= mv_line;
            lg_src[mv_n % 64]   <= mv_src_node;
            lg_dst[mv_n % 64]   <= mv_dst_node;
            lg_dir[mv_n % 64]   <= mv_dir;
            lg_dnode[mv_n % 64] <= mv_dir_node;
            mv_n <= mv_n + 1;
         end
         if (msg_valid) begin
            lg_kind[msg_n % 64]  <= msg_kind;
            lg_mnode[msg_n % 64] <= msg_node;
            msg_n         <= msg_n + 1;
            msg_rsp_valid <= 1'b1;
            msg_rsp_owner <= cfg_owner;
            msg_rsp_hit   <= (msg_kind == 2'd0) ? cfg_shr_hit :
                             (msg_kind == 2'd1) ? cfg_dir_hit : cfg_probe_hit;
         end
         if (rsp_valid) begin
            lg_rsp[rsp_n % 64] <= rsp_src;
            rsp_n <= rsp_n + 1;
         end
         if (lk_valid) lk_seen <= line_addr;
         if (!req_ready && req_ready !== 1'bx && mem_req_valid) busy_ready <= busy_ready;
         if (req_ready && mem_req_valid) busy_ready <= busy_ready + 1;
         if (mem_req_valid) begin
            mem_run <= mem_run + 1;
            if (mem_run + 1 == MEM_LAT) begin
               mem_rsp_valid <= 1'b1;
               mem_last      <= mem_run + 1;
            end
         end else begin
            mem_run <= 0;
         end
      end
   end

   int total = 0, bad = 0;
   int mv0, msg0, rsp0;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NODE_W-1:0] home_of(input logic [LINE_W-1:0] l);
      return NODE_W'(l % NODES);
   endfunction

   task automatic run_req(input logic [LINE_W-1:0] line);
      mv0 = mv_n; msg0 = msg_n; rsp0 = rsp_n;
      @(negedge clk);
      req_line  = line;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (rsp_n != rsp0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      check("R11", "response pulses", rsp_n - rsp0, 1);
   endtask

   task automatic set_cfg(input logic ph, input logic sh, input logic hs, input logic dh,
                          input logic [NODE_W-1:0] ow, input logic pr, input logic vv,
                          input logic [LINE_W-1:0] vl);
      lk_priv_hit = ph; lk_shr_hit = sh; cfg_shr_hit = hs; cfg_dir_hit = dh;
      cfg_owner = ow; cfg_probe_hit = pr; vic_valid = vv; vic_line = vl;
   endtask

   task automatic t_reset;
      check("R1", "req_ready", req_ready, 1);
      check("R1", "valids", {rsp_valid, lk_valid, msg_valid, mem_req_valid, mv_valid}, 0);
   endtask

   task automatic t_local_priv;
      logic [LINE_W-1:0] l = 26'h0_1234;
      set_cfg(1, 0, 0, 0, 0, 0, 0, '0);
      run_req(l);
      check("R2", "lookup line", lk_seen, l);
      check("R3", "rsp_src", lg_rsp[rsp0 % 64], 0);
      check("R3", "moves", mv_n - mv0, 0);
      check("R3", "messages", msg_n - msg0, 0);
   endtask

   task automatic t_local_shr;
      logic [LINE_W-1:0] l = 26'h0_2222;   // home 2
      set_cfg(0, 1, 0, 0, 0, 0, 0, '0);
      run_req(l);
      check("R4", "rsp_src", lg_rsp[rsp0 % 64], 1);
      check("R4", "moves", mv_n - mv0, 1);
      check("R4", "op", lg_op[mv0 % 64], 1);
      check("R4", "src/dst", {lg_src[mv0 % 64], lg_dst[mv0 % 64]}, {ME, ME});
      check("R4", "dir", lg_dir[mv0 % 64], 1);
      check("R9", "dir node", lg_dnode[mv0 % 64], home_of(l));
   endtask

   task automatic t_home_shr;
      logic [LINE_W-1:0] l = 26'h0_3333;   // home 3
      set_cfg(0, 0, 1, 0, 0, 0, 0, '0);
      run_req(l);
      check("R5", "msg kind", lg_kind[msg0 % 64], 0);
      check("R5", "msg node", lg_mnode[msg0 % 64], home_of(l));
      check("R5", "rsp_src", lg_rsp[rsp0 % 64], 2);
      check("R5", "move src", lg_src[mv0 % 64], home_of(l));
      check("R5", "move op/dir", {lg_op[mv0 % 64], lg_dir[mv0 % 64]}, {2'd1, 2'd1});
   endtask

   task automatic t_own_home;
      logic [LINE_W-1:0] l = 26'h0_0101;   // home 1 == node
      set_cfg(0, 0, 1, 0, 0, 0, 0, '0);
      run_req(l);
      check("R5", "first msg kind (skip own home)", lg_kind[msg0 % 64], 1);
      check("R5", "messages", msg_n - msg0, 1);
      check("R7", "rsp_src", lg_rsp[rsp0 % 64], 4);
   endtask

   task automatic t_remote;
      logic [LINE_W-1:0] l = 26'h0_4446;   // home 2
      set_cfg(0, 0, 0, 1, 2'd3, 1, 0, '0);
      run_req(l);
      check("R6", "messages", msg_n - msg0, 3);
      check("R6", "dir kind/node", {lg_kind[(msg0+1) % 64], lg_mnode[(msg0+1) % 64]}, {2'd1, 2'd2});
      check("R6", "probe kind/node", {lg_kind[(msg0+2) % 64], lg_mnode[(msg0+2) % 64]}, {2'd2, 2'd3});
      check("R6", "rsp_src", lg_rsp[rsp0 % 64], 3);
      check("R6", "move op", lg_op[mv0 % 64], 2);
      check("R6", "move src/dst", {lg_src[mv0 % 64], lg_dst[mv0 % 64]}, {2'd3, 2'd2});
      check("R6", "dir clr/node", {lg_dir[mv0 % 64], lg_dnode[mv0 % 64]}, {2'd2, 2'd2});
      check("R6", "moves", mv_n - mv0, 1);
   endtask

   task automatic t_offchip;
      logic [LINE_W-1:0] l = 26'h0_5554;   // home 0
      set_cfg(0, 0, 0, 0, 0, 0, 0, '0);
      run_req(l);
      check("R7", "mem held cycles", mem_last, MEM_LAT);
      check("R2", "ready while busy", busy_ready, 0);
      check("R7", "rsp_src", lg_rsp[rsp0 % 64], 4);
      check("R7", "move op/dir", {lg_op[mv0 % 64], lg_dir[mv0 % 64]}, {2'd3, 2'd1});
      check("R7", "move dst/dnode", {lg_dst[mv0 % 64], lg_dnode[mv0 % 64]}, {ME, 2'd0});
      check("R7", "move line", lg_line[mv0 % 64], l);
   endtask

   task automatic t_probe_miss;
      logic [LINE_W-1:0] l = 26'h0_6663;   // home 3
      set_cfg(0, 0, 0, 1, 2'd2, 0, 0, '0);
      run_req(l);
      check("R7", "probe-miss rsp_src", lg_rsp[rsp0 % 64], 4);
      check("R7", "probe-miss op", lg_op[mv0 % 64], 3);
   endtask

   task automatic t_victim;
      logic [LINE_W-1:0] l  = 26'h0_7770;  // home 0
      logic [LINE_W-1:0] vl = 26'h0_0ABF;  // home 3
      set_cfg(0, 0, 0, 0, 0, 0, 1, vl);
      run_req(l);
      vic_valid = 1'b0;
      check("R8", "moves", mv_n - mv0, 2);
      check("R8", "vic op", lg_op[(mv0+1) % 64], 2);
      check("R8", "vic line", lg_line[(mv0+1) % 64], vl);
      check("R8", "vic src/dst", {lg_src[(mv0+1) % 64], lg_dst[(mv0+1) % 64]}, {ME, home_of(vl)});
      check("R8", "vic dir/node", {lg_dir[(mv0+1) % 64], lg_dnode[(mv0+1) % 64]}, {2'd2, 2'd3});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_local_priv();
      t_local_shr();
      t_home_shr();
      t_own_home();
      t_remote();
      t_offchip();
      t_probe_miss();
      t_victim();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", WD_CYC, WD_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule